// File: doc/BRIEF.md
# PC Card Memory Bus Decoder

This block is the card-side control logic between a 16-bit PC Card memory host bus and the memories on the card. The common memory is built from identical 8-bit flash devices arranged in pairs, and the card also holds a small byte-wide attribute memory. The block decodes the two card enables, address bit 0, the attribute-plane select and the read and write strobes. From them it produces a low-byte chip select and a high-byte chip select for each device pair, a select for the attribute memory, and the shared device address and strobes.

Data moves between the host bus halves and the device byte lanes. Even bytes always use the low byte lane of a pair and odd bytes always use the high byte lane. A byte-wide host, however, sees every byte on the low host lane, because the block swaps the odd byte down when address bit 0 is set. The host tri-state buffers are modelled as two drive enables, one per lane.

The number of pairs and the device size are parameters. Host address bits above the next power of two of the card size are ignored, so the address space wraps there. Pair slots that lie inside the wrap window but have no devices fitted select nothing. A write-protect input blocks every strobe to the flash array.

Top module: `card_bus_decoder`

## Requirements
- R1: With ce1_n and ce2_n both high (standby), no chip select or attribute select is active, neither host lane is driven, and no write strobe is issued, whatever oe_n, we_n and reg_n are.
- R2: With ce1_n low, ce2_n high and host_addr[0] = 0 (even byte access), the even byte of the addressed location is read on host_rdata[7:0] and written from host_wdata[7:0]. Only the low-lane chip select of the pair is active, and host_drv_hi stays low.
- R3: With ce1_n low, ce2_n high and host_addr[0] = 1 (odd byte access), the odd byte is read on host_rdata[7:0] and written from host_wdata[7:0]. Only the high-lane chip select is active, and host_drv_hi stays low.
- R4: With ce1_n and ce2_n both low (word access), host_addr[0] is ignored. The even byte moves on bits [7:0], the odd byte moves on bits [15:8], and both chip selects of the pair are active.
- R5: With ce1_n high and ce2_n low (odd-only access), the odd byte moves on bits [15:8], only the high-lane chip select is active, and host_drv_lo stays low.
- R6: With reg_n low, no common-memory chip select is active. The attribute memory is selected only for even-byte or word access, at attr_addr = host_addr[ATTR_ADDR_W:1], and is read on host_rdata[7:0] and written from host_wdata[7:0]. host_drv_hi is never set in this plane, and an odd-byte or odd-only access drives no lane.
- R7: The pair index is host_addr[DEV_ADDR_W+1 +: PAIR_W] and the device offset is host_addr[DEV_ADDR_W:1]. At most one pair's low-lane select and one pair's high-lane select are active at a time.
- R8: Host address bits at and above DEV_ADDR_W+1+PAIR_W are ignored. A pair index of NUM_PAIRS or more selects no device, drives no lane and issues no flash strobe.
- R9: While wp is high, flash_we_n stays high and the flash contents are unchanged. Attribute memory writes are unaffected.
- R10: A host lane is driven only while oe_n is low and we_n is high. A write strobe (flash_we_n or attr_we_n low) is issued only while we_n is low and oe_n is high, so oe_n and we_n both low do nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| host_addr | input | HOST_ADDR_W | Host byte address; bit 0 picks the byte in byte mode |
| ce1_n | input | 1 | Even-byte card enable, active low |
| ce2_n | input | 1 | Odd-byte card enable, active low |
| reg_n | input | 1 | Attribute plane select, active low |
| oe_n | input | 1 | Host read strobe, active low |
| we_n | input | 1 | Host write strobe, active low |
| wp | input | 1 | Write protect, high blocks flash writes |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Read data toward the host |
| host_drv_lo | output | 1 | Drive enable of host lane [7:0] |
| host_drv_hi | output | 1 | Drive enable of host lane [15:8] |
| dev_addr | output | DEV_ADDR_W | Offset inside each device |
| mem_oe_n | output | 1 | Shared device read strobe, active low |
| flash_we_n | output | 1 | Flash write strobe, active low |
| dev_wdata_lo | output | 8 | Write byte for even devices and attribute memory |
| dev_wdata_hi | output | 8 | Write byte for odd devices |
| sel_lo | output | NUM_PAIRS | Even-device select per pair, active high |
| sel_hi | output | NUM_PAIRS | Odd-device select per pair, active high |
| dev_rdata_lo | input | 8*NUM_PAIRS | Even-device read bytes, pair p at [8p+7:8p] |
| dev_rdata_hi | input | 8*NUM_PAIRS | Odd-device read bytes, pair p at [8p+7:8p] |
| attr_sel | output | 1 | Attribute memory select, active high |
| attr_addr | output | ATTR_ADDR_W | Attribute memory byte index |
| attr_we_n | output | 1 | Attribute write strobe, active low |
| attr_rdata | input | 8 | Attribute memory read byte |

## Verification
Lane steering and the write-protect or wrap gating act in the same cycle. An odd-byte write under protection, or a word write to an address above the wrap point, must both route its data to the right lane and decide whether the strobe fires at all. The bench sweeps every combination of the six control inputs across pseudo-random addresses, including aliased addresses and unpopulated pair slots. Each cycle is judged against a flat byte-array model of the card. Later reads of the same bytes show whether a blocked or aliased write landed where the model says.

// File: rtl/card_bus_pkg.sv
package card_bus_pkg;

   typedef enum logic [2:0] {
      ACC_IDLE      = 3'd0,
      ACC_BYTE_EVEN = 3'd1,
      ACC_BYTE_ODD  = 3'd2,
      ACC_WORD      = 3'd3,
      ACC_ODD_ONLY  = 3'd4
   } acc_kind_e;

   function automatic logic needs_even_dev(acc_kind_e k);
      return (k == ACC_BYTE_EVEN) || (k == ACC_WORD);
   endfunction

   function automatic logic needs_odd_dev(acc_kind_e k);
      return (k == ACC_BYTE_ODD) || (k == ACC_WORD) || (k == ACC_ODD_ONLY);
   endfunction

   function automatic logic uses_low_lane(acc_kind_e k);
      return (k == ACC_BYTE_EVEN) || (k == ACC_BYTE_ODD) || (k == ACC_WORD);
   endfunction

   function automatic logic uses_high_lane(acc_kind_e k);
      return (k == ACC_WORD) || (k == ACC_ODD_ONLY);
   endfunction

endpackage

// File: rtl/card_access_decode.sv
module card_access_decode
   import card_bus_pkg::*;
(
   input  logic      ce1_n,
   input  logic      ce2_n,
   input  logic      a0,
   output acc_kind_e kind
);
   always_comb begin
      case ({ce2_n, ce1_n})
         2'b11:   kind = ACC_IDLE;
         2'b10:   kind = a0 ? ACC_BYTE_ODD : ACC_BYTE_EVEN;
         2'b00:   kind = ACC_WORD;
         default: kind = ACC_ODD_ONLY;
      endcase
   end
endmodule

// File: rtl/card_pair_select.sv
module card_pair_select #(
   parameter int HOST_ADDR_W = 12,
   parameter int DEV_ADDR_W  = 8,
   parameter int NUM_PAIRS   = 3,
   parameter int PAIR_W      = 2
) (
   input  logic [HOST_ADDR_W-1:0] addr,
   output logic [NUM_PAIRS-1:0]   pair_hit,
   output logic                   populated
);
   localparam int IDX_LSB = DEV_ADDR_W + 1;
   localparam int SPAN_W  = IDX_LSB + PAIR_W;

   logic [PAIR_W-1:0] idx;

   generate
      if (NUM_PAIRS == 1) begin : g_single
         logic unused_idx;
         assign unused_idx = ^addr[IDX_LSB +: PAIR_W];
         assign idx        = '0;
         assign populated  = 1'b1;
      end else begin : g_multi
         assign idx       = addr[IDX_LSB +: PAIR_W];
         assign populated = (32'(idx) < NUM_PAIRS);
      end

      if (HOST_ADDR_W > SPAN_W) begin : g_wrap
         logic unused_wrap;
         assign unused_wrap = ^addr[HOST_ADDR_W-1:SPAN_W];
      end

      for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_hit
         assign pair_hit[p] = populated && (32'(idx) == p);
      end
   endgenerate
endmodule

// File: rtl/card_lane_steer.sv
module card_lane_steer
   import card_bus_pkg::*;
#(
   parameter int NUM_PAIRS = 3
) (
   input  acc_kind_e              kind,
   input  logic                   attr_path,
   input  logic [NUM_PAIRS-1:0]   pair_hit,
   input  logic [NUM_PAIRS*8-1:0] rdata_lo,
   input  logic [NUM_PAIRS*8-1:0] rdata_hi,
   input  logic [7:0]             attr_rdata,
   input  logic [15:0]            host_wdata,
   output logic [15:0]            host_rdata,
   output logic [7:0]             wdata_lo,
   output logic [7:0]             wdata_hi
);
   logic [7:0] pick_lo, pick_hi;
   logic       swap_down;

   assign swap_down = (kind == ACC_BYTE_ODD);

   always_comb begin
      pick_lo = '0;
      pick_hi = '0;
      for (int p = 0; p < NUM_PAIRS; p++) begin
         pick_lo = pick_lo | (rdata_lo[p*8 +: 8] & {8{pair_hit[p]}});
         pick_hi = pick_hi | (rdata_hi[p*8 +: 8] & {8{pair_hit[p]}});
      end
   end

   assign host_rdata[7:0]  = attr_path ? attr_rdata : (swap_down ? pick_hi : pick_lo);
   assign host_rdata[15:8] = pick_hi;
   assign wdata_lo         = host_wdata[7:0];
   assign wdata_hi         = swap_down ? host_wdata[7:0] : host_wdata[15:8];
endmodule

// File: rtl/card_bus_decoder.sv
module card_bus_decoder
   import card_bus_pkg::*;
#(
   parameter int HOST_ADDR_W = 12,
   parameter int DEV_ADDR_W  = 8,
   parameter int NUM_PAIRS   = 3,
   parameter int ATTR_ADDR_W = 6,
   parameter bit ATTR_EN     = 1'b1
) (
   input  logic [HOST_ADDR_W-1:0] host_addr,
   input  logic                   ce1_n,
   input  logic                   ce2_n,
   input  logic                   reg_n,
   input  logic                   oe_n,
   input  logic                   we_n,
   input  logic                   wp,
   input  logic [15:0]            host_wdata,
   output logic [15:0]            host_rdata,
   output logic                   host_drv_lo,
   output logic                   host_drv_hi,
   output logic [DEV_ADDR_W-1:0]  dev_addr,
   output logic                   mem_oe_n,
   output logic                   flash_we_n,
   output logic [7:0]             dev_wdata_lo,
   output logic [7:0]             dev_wdata_hi,
   output logic [NUM_PAIRS-1:0]   sel_lo,
   output logic [NUM_PAIRS-1:0]   sel_hi,
   input  logic [NUM_PAIRS*8-1:0] dev_rdata_lo,
   input  logic [NUM_PAIRS*8-1:0] dev_rdata_hi,
   output logic                   attr_sel,
   output logic [ATTR_ADDR_W-1:0] attr_addr,
   output logic                   attr_we_n,
   input  logic [7:0]             attr_rdata
);
   localparam int PAIR_W = (NUM_PAIRS > 1) ? $clog2(NUM_PAIRS) : 1;
   localparam int SPAN_W = DEV_ADDR_W + 1 + PAIR_W;

   generate
      if (NUM_PAIRS < 1 || NUM_PAIRS > 10) begin : g_bad_pairs
         $error("NUM_PAIRS must lie in 1..10");
      end
      if (HOST_ADDR_W < SPAN_W) begin : g_bad_addr
         $error("HOST_ADDR_W too narrow for the pair span");
      end
      if (ATTR_ADDR_W + 1 > HOST_ADDR_W) begin : g_bad_attr
         $error("ATTR_ADDR_W too wide for the host address");
      end
   endgenerate

   acc_kind_e            kind;
   logic [NUM_PAIRS-1:0] pair_hit;
   logic                 populated;
   logic                 rd_cyc, wr_cyc, common_hit;

   card_access_decode u_decode (
      .ce1_n (ce1_n),
      .ce2_n (ce2_n),
      .a0    (host_addr[0]),
      .kind  (kind)
   );

   card_pair_select #(
      .HOST_ADDR_W (HOST_ADDR_W),
      .DEV_ADDR_W  (DEV_ADDR_W),
      .NUM_PAIRS   (NUM_PAIRS),
      .PAIR_W      (PAIR_W)
   ) u_pairs (
      .addr      (host_addr),
      .pair_hit  (pair_hit),
      .populated (populated)
   );

   assign rd_cyc     = !oe_n && we_n;
   assign wr_cyc     = !we_n && oe_n;
   assign common_hit = reg_n && populated;

   generate
      if (ATTR_EN) begin : g_attr
         assign attr_sel = !reg_n && needs_even_dev(kind);
      end else begin : g_no_attr
         assign attr_sel = 1'b0;
      end
   endgenerate

   assign attr_addr = host_addr[ATTR_ADDR_W:1];
   assign attr_we_n = !(wr_cyc && attr_sel);

   assign sel_lo   = (common_hit && needs_even_dev(kind)) ? pair_hit : '0;
   assign sel_hi   = (common_hit && needs_odd_dev(kind))  ? pair_hit : '0;
   assign dev_addr = host_addr[DEV_ADDR_W:1];
   assign mem_oe_n = !rd_cyc;

   assign flash_we_n  = !(wr_cyc && common_hit && !wp && (kind != ACC_IDLE));
   assign host_drv_lo = rd_cyc && ((common_hit && uses_low_lane(kind)) || attr_sel);
   assign host_drv_hi = rd_cyc && common_hit && uses_high_lane(kind);

   card_lane_steer #(
      .NUM_PAIRS (NUM_PAIRS)
   ) u_steer (
      .kind       (kind),
      .attr_path  (attr_sel),
      .pair_hit   (pair_hit),
      .rdata_lo   (dev_rdata_lo),
      .rdata_hi   (dev_rdata_hi),
      .attr_rdata (attr_rdata),
      .host_wdata (host_wdata),
      .host_rdata (host_rdata),
      .wdata_lo   (dev_wdata_lo),
      .wdata_hi   (dev_wdata_hi)
   );
endmodule

// File: rtl/card_bus_decoder_chk.sv
module card_bus_decoder_chk #(
   parameter int NUM_PAIRS = 3
) (
   input logic                 ce1_n,
   input logic                 ce2_n,
   input logic                 reg_n,
   input logic                 oe_n,
   input logic                 we_n,
   input logic                 wp,
   input logic                 host_drv_lo,
   input logic                 host_drv_hi,
   input logic [NUM_PAIRS-1:0] sel_lo,
   input logic [NUM_PAIRS-1:0] sel_hi,
   input logic                 attr_sel,
   input logic                 flash_we_n,
   input logic                 attr_we_n
);
   always_comb begin
      // R1
      standby_quiet_chk: assert (!(ce1_n && ce2_n) ||
         (sel_lo == '0 && sel_hi == '0 && !attr_sel && !host_drv_lo &&
          !host_drv_hi && flash_we_n && attr_we_n))
         else $error("standby not quiet");
      // R10
      drive_only_read_chk: assert (!(host_drv_lo || host_drv_hi) || (!oe_n && we_n))
         else $error("lane driven outside read");
      // R10
      strobe_only_write_chk: assert ((flash_we_n && attr_we_n) || (!we_n && oe_n))
         else $error("write strobe outside write");
      // R9
      wp_lock_chk: assert (!wp || flash_we_n)
         else $error("flash strobe while protected");
      // R6
      attr_exclusive_chk: assert (!attr_sel ||
         (!reg_n && sel_lo == '0 && sel_hi == '0 && !host_drv_hi))
         else $error("attribute select overlaps common memory");
      // R7
      one_pair_chk: assert ($onehot0(sel_lo) && $onehot0(sel_hi))
         else $error("more than one pair selected");
      // R5
      odd_only_low_quiet_chk: assert (!ce1_n || !host_drv_lo)
         else $error("low lane driven without ce1_n");
   end
endmodule

bind card_bus_decoder card_bus_decoder_chk #(.NUM_PAIRS(NUM_PAIRS)) u_chk (
   .ce1_n       (ce1_n),
   .ce2_n       (ce2_n),
   .reg_n       (reg_n),
   .oe_n        (oe_n),
   .we_n        (we_n),
   .wp          (wp),
   .host_drv_lo (host_drv_lo),
   .host_drv_hi (host_drv_hi),
   .sel_lo      (sel_lo),
   .sel_hi      (sel_hi),
   .attr_sel    (attr_sel),
   .flash_we_n  (flash_we_n),
   .attr_we_n   (attr_we_n)
);

// File: tb/card_bus_decoder_tb.sv
`timescale 1ns/1ps
module card_bus_decoder_tb;
   localparam int HAW = 12;
   localparam int DAW = 8;
   localparam int NP  = 3;
   localparam int AAW = 6;
   localparam int DEPTH = 1 << DAW;
   localparam int FLAT  = NP * 2 * DEPTH;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #10 clk = ~clk;

   logic [HAW-1:0] host_addr = '0;
   logic ce1_n = 1'b1, ce2_n = 1'b1, reg_n = 1'b1, oe_n = 1'b1, we_n = 1'b1, wp = 1'b0;
   logic [15:0] host_wdata = '0;
   logic [15:0] host_rdata;
   logic host_drv_lo, host_drv_hi, mem_oe_n, flash_we_n, attr_sel, attr_we_n;
   logic [DAW-1:0] dev_addr;
   logic [7:0] dev_wdata_lo, dev_wdata_hi, attr_rdata;
   logic [NP-1:0] sel_lo, sel_hi;
   logic [NP*8-1:0] dev_rdata_lo, dev_rdata_hi;
   logic [AAW-1:0] attr_addr;

   card_bus_decoder #(.HOST_ADDR_W(HAW), .DEV_ADDR_W(DAW), .NUM_PAIRS(NP),
                      .ATTR_ADDR_W(AAW), .ATTR_EN(1'b1)) u_dut (
      .host_addr(host_addr), .ce1_n(ce1_n), .ce2_n(ce2_n), .reg_n(reg_n),
      .oe_n(oe_n), .we_n(we_n), .wp(wp), .host_wdata(host_wdata),
      .host_rdata(host_rdata), .host_drv_lo(host_drv_lo), .host_drv_hi(host_drv_hi),
      .dev_addr(dev_addr), .mem_oe_n(mem_oe_n), .flash_we_n(flash_we_n),
      .dev_wdata_lo(dev_wdata_lo), .dev_wdata_hi(dev_wdata_hi),
      .sel_lo(sel_lo), .sel_hi(sel_hi), .dev_rdata_lo(dev_rdata_lo),
      .dev_rdata_hi(dev_rdata_hi), .attr_sel(attr_sel), .attr_addr(attr_addr),
      .attr_we_n(attr_we_n), .attr_rdata(attr_rdata));

   // behavioural byte-wide devices on the card
   logic [7:0] dev_lo [NP][DEPTH];
   logic [7:0] dev_hi [NP][DEPTH];
   logic [7:0] attr_m [1 << AAW];
   // reference model: flat card byte image
   logic [7:0] ref_mem [FLAT];
   logic [7:0] ref_attr [1 << AAW];

   function automatic logic [7:0] seed_byte(int i);
      return 8'((i * 37 + 11) ^ (i >> 3));
   endfunction

   initial begin
      for (int p = 0; p < NP; p++)
         for (int o = 0; o < DEPTH; o++) begin
            dev_lo[p][o] = seed_byte(p*2*DEPTH + 2*o);
            dev_hi[p][o] = seed_byte(p*2*DEPTH + 2*o + 1);
         end
      for (int i = 0; i < FLAT; i++) ref_mem[i] = seed_byte(i);
      for (int i = 0; i < (1 << AAW); i++) begin
         attr_m[i]   = 8'(i * 5 + 129);
         ref_attr[i] = 8'(i * 5 + 129);
      end
   end

   always_comb begin
      for (int p = 0; p < NP; p++) begin
         dev_rdata_lo[p*8 +: 8] = dev_lo[p][dev_addr];
         dev_rdata_hi[p*8 +: 8] = dev_hi[p][dev_addr];
      end
      attr_rdata = attr_m[attr_addr];
   end

   always @(posedge clk) begin
      if (!flash_we_n)
         for (int p = 0; p < NP; p++) begin
            if (sel_lo[p]) dev_lo[p][dev_addr] <= dev_wdata_lo;
            if (sel_hi[p]) dev_hi[p][dev_addr] <= dev_wdata_hi;
         end
      if (!attr_we_n && attr_sel) attr_m[attr_addr] <= dev_wdata_lo;
   end

   int vectors = 0;
   int errors  = 0;
   bit finished = 1'b0;

   task automatic check(string tg, string what, int act, int exp);
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h", tg, what, act, exp);
      end
   endtask

   task automatic apply(bit c1, bit c2, bit rg, bit oe, bit we, bit wpi,
                        logic [HAW-1:0] a, logic [15:0] wd, string tg_in);
      string tg;
      int flat, ev, od, pidx;
      bit pop, bev, bod, wrd, oonly, idle, rd, wr, even_w, odd_w;
      bit e_lo, e_hi, e_attr, e_fwe;
      @(negedge clk);
      ce1_n = c1; ce2_n = c2; reg_n = rg; oe_n = oe; we_n = we; wp = wpi;
      host_addr = a; host_wdata = wd;
      #5;
      vectors++;
      flat  = int'(a[DAW+2:0]);          // R8: wrap at the pair-span boundary
      pidx  = flat / (2*DEPTH);
      pop   = pidx < NP;
      ev    = flat & ~1;
      od    = flat | 1;
      idle  = c1 && c2;
      bev   = !c1 && c2 && !a[0];
      bod   = !c1 && c2 && a[0];
      wrd   = !c1 && !c2;
      oonly = c1 && !c2;
      rd    = !oe && we;
      wr    = !we && oe;
      even_w = bev || wrd;
      odd_w  = bod || wrd || oonly;
      if (tg_in != "") tg = tg_in;
      else if (idle) tg = "R1";
      else if (!oe && !we) tg = "R10";
      else if (!rg) tg = "R6";
      else if (!pop || a[HAW-1]) tg = "R8";
      else if (wpi && wr) tg = "R9";
      else if (bev) tg = "R2";
      else if (bod) tg = "R3";
      else if (wrd) tg = "R4";
      else tg = "R5";
      if (rg) begin
         e_lo  = rd && pop && (bev || bod || wrd);
         e_hi  = rd && pop && (wrd || oonly);
         e_attr = 1'b0;
         e_fwe = wr && pop && !wpi && !idle;
      end else begin
         e_lo  = rd && even_w;
         e_hi  = 1'b0;
         e_attr = even_w;
         e_fwe = 1'b0;
      end
      check(tg, "host_drv_lo", host_drv_lo, e_lo);
      check(tg, "host_drv_hi", host_drv_hi, e_hi);
      check(tg, "attr_sel", attr_sel, e_attr);
      check(tg, "flash strobe", !flash_we_n, e_fwe);
      check(tg, "sel_lo count", $countones(sel_lo), (rg && pop && even_w) ? 1 : 0);
      check(tg, "sel_hi count", $countones(sel_hi), (rg && pop && odd_w) ? 1 : 0);
      if (e_lo) begin
         if (!rg) check(tg, "attr byte", host_rdata[7:0], ref_attr[a[AAW:1]]);
         else if (bod) check(tg, "odd byte on low lane", host_rdata[7:0], ref_mem[od]);
         else check(tg, "even byte", host_rdata[7:0], ref_mem[ev]);
      end
      if (e_hi) check(tg, "odd byte on high lane", host_rdata[15:8], ref_mem[od]);
      @(posedge clk);
      if (wr && rg && pop && !wpi) begin
         if (bev) ref_mem[ev] = wd[7:0];
         if (bod) ref_mem[od] = wd[7:0];
         if (wrd) begin ref_mem[ev] = wd[7:0]; ref_mem[od] = wd[15:8]; end
         if (oonly) ref_mem[od] = wd[15:8];
      end
      if (wr && !rg && even_w) ref_attr[a[AAW:1]] = wd[7:0];
   endtask

   // shorthand: read / write helpers (c1,c2 given)
   task automatic rdv(bit c1, bit c2, bit rg, logic [HAW-1:0] a, string tg);
      apply(c1, c2, rg, 1'b0, 1'b1, 1'b0, a, 16'h0, tg);
   endtask
   task automatic wrv(bit c1, bit c2, bit rg, bit wpi, logic [HAW-1:0] a,
                      logic [15:0] d, string tg);
      apply(c1, c2, rg, 1'b1, 1'b0, wpi, a, d, tg);
   endtask

   initial begin
      int seed;
      repeat (3) @(posedge clk);
      // reset state: standby outputs
      apply(1, 1, 1, 1, 1, 0, 12'h000, 16'h0, "R1");
      rst_n = 1'b1;
      apply(1, 1, 1, 0, 1, 0, 12'h010, 16'h0, "R1");
      apply(1, 1, 0, 1, 0, 0, 12'h010, 16'hA5A5, "R1");
      // byte even / odd
      rdv(0, 1, 1, 12'h020, "R2");
      rdv(0, 1, 1, 12'h021, "R3");
      wrv(0, 1, 1, 0, 12'h021, 16'h003C, "R3");
      rdv(0, 0, 1, 12'h020, "R3");
      wrv(0, 1, 1, 0, 12'h044, 16'hFF5A, "R2");
      rdv(0, 0, 1, 12'h045, "R2");
      // word with A0 ignored
      rdv(0, 0, 1, 12'h131, "R4");
      wrv(0, 0, 1, 0, 12'h0C7, 16'hBEEF, "R4");
      rdv(0, 1, 1, 12'h0C6, "R4");
      rdv(0, 1, 1, 12'h0C7, "R4");
      // odd only
      rdv(1, 0, 1, 12'h202, "R5");
      wrv(1, 0, 1, 0, 12'h202, 16'h7E00, "R5");
      rdv(0, 0, 1, 12'h202, "R5");
      // attribute plane
      rdv(0, 1, 0, 12'h00A, "R6");
      rdv(0, 1, 0, 12'h00B, "R6");
      rdv(0, 0, 0, 12'h00A, "R6");
      rdv(1, 0, 0, 12'h00A, "R6");
      wrv(0, 1, 0, 0, 12'h00A, 16'h1234, "R6");
      rdv(0, 1, 0, 12'h00A, "R6");
      rdv(0, 0, 1, 12'h00A, "R6");
      // every pair, several offsets
      for (int p = 0; p < NP; p++)
         for (int o = 0; o < 4; o++)
            rdv(0, 0, 1, HAW'(p*2*DEPTH + o*62 + 1), "R7");
      // wrap and unpopulated slot
      wrv(0, 0, 1, 0, 12'h806, 16'hC0DE, "R8");
      rdv(0, 0, 1, 12'h006, "R8");
      rdv(0, 1, 1, 12'h600, "R8");
      wrv(0, 0, 1, 0, 12'h610, 16'h9999, "R8");
      rdv(0, 0, 1, 12'h010, "R8");
      // write protect
      wrv(0, 0, 1, 1, 12'h100, 16'h5555, "R9");
      rdv(0, 0, 1, 12'h100, "R9");
      wrv(0, 1, 0, 1, 12'h014, 16'h0077, "R9");
      rdv(0, 1, 0, 12'h014, "R9");
      // both strobes low
      apply(0, 0, 1, 0, 0, 0, 12'h0A0, 16'h4321, "R10");
      rdv(0, 0, 1, 12'h0A0, "R10");
      apply(0, 1, 0, 0, 0, 0, 12'h01C, 16'h00EE, "R10");
      rdv(0, 1, 0, 12'h01C, "R10");
      // sweep every control combination over pseudo-random addresses
      seed = 32'h1ACE;
      for (int ctl = 0; ctl < 64; ctl++)
         for (int k = 0; k < 8; k++) begin
            seed = seed ^ (seed << 13); seed = seed ^ (seed >> 17); seed = seed ^ (seed << 5);
            apply(ctl[0], ctl[1], ctl[2], ctl[3], ctl[4], ctl[5],
                  HAW'(seed), 16'(seed >> 12), "");
            rdv(0, 0, 1, HAW'(seed), "");
         end
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
   end

   initial begin
      #(20 * 150000);
      if (!finished) begin
         errors++;
         $display("FAIL watchdog: actual hung expected done");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
         $finish;
      end
   end
endmodule